// File: doc/BRIEF.md
# Sticky Power Event Status Register

This block is a power-management status word that remembers wake and clock-health events until software acknowledges them. Five flags are kept. One records a debounced press of the on-key. Three record that a PLL lock-detect signal has dropped: one each for the system, communications and display PLLs. The last records that a power-on reset took place. Each flag reports that its condition occurred at some point since software last cleared it. None of them follows the live level of its input.

Software reads the flags through a small register port: an address, a write strobe, write data and combinational read data. A flag is cleared by writing a one to its bit position. Writing zero leaves a bit alone. An interrupt request stays high for as long as the key flag is set.

The asynchronous key and lock-detect lines are synchronised inside the block. The key line also passes through a counter-based debouncer whose stable period is a parameter. There are two reset inputs. The power-on reset clears everything and sets the power-on flag. The warm reset clears everything except the power-on flag.

Top module: `pwr_evt_status`

## Requirements
- R1: While `por_n` is low and after it is released, the status word reads 0x00000001: only bit 0 is set. `irq` is low.
- R2: Bit 4, the key flag, sets only after the synchronised key line (1 = pressed) has been high for `DEB_CYCLES` consecutive clocks. A shorter pulse leaves the flag clear.
- R3: Writing 1 to bit 4 clears the key flag. A write with bit 4 at 0 leaves it set.
- R4: A 1-to-0 transition of `pll_lock[2]`, `pll_lock[1]` or `pll_lock[0]` sets bit 3, bit 2 or bit 1 respectively. A 0-to-1 transition sets nothing.
- R5: Writing 1 to one of bits 3 to 0 clears that flag and no other flag.
- R6: When a new event and a clear of the same bit fall in the same cycle, the flag ends up set.
- R7: Bit 0 is set by `por_n` and is not changed by `rst_n`. It is cleared by writing 1 to bit 0.
- R8: Bits 31 to 5 of the status word read 0. An address other than `STATUS_ADDR` reads 0, and a write to such an address clears nothing.
- R9: `irq` equals the key flag at all times.
- R10: A set flag stays set after its input condition goes away, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, asynchronous, active low |
| key_raw | input | 1 | Asynchronous on-key line, 1 = pressed |
| pll_lock | input | NUM_PLL | Lock-detect lines: [2] system, [1] comms, [0] display |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data; a 1 bit clears the matching flag |
| reg_rdata | output | DATA_W | Status word when the address matches, otherwise 0 |
| irq | output | 1 | Key-event interrupt request |

## Verification
The bench builds the block with `DEB_CYCLES` = 4. With that value, every key pulse length from one clock to a few clocks past the threshold can be swept, so both sides of the debounce boundary are reached. The three lock lines are small enough that all eight drop patterns are tried, each followed by re-lock and by one clear per bit. A lock drop is timed against a same-cycle clear, and warm and power-on resets are interleaved with clears of bit 0.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int NUM_PLL     = 3;
  localparam int FLAG_POR    = 0;
  localparam int FLAG_PLL_LO = 1;
  localparam int FLAG_KEY    = FLAG_PLL_LO + NUM_PLL;
  localparam int NUM_FLAGS   = FLAG_KEY + 1;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwr_key_debounce.sv
module pwr_key_debounce #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_sync_i,
  output logic level_o,
  output logic press_o
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             level_q;
  logic             differ;
  logic             done;

  assign differ = key_sync_i != level_q;
  assign done   = differ && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (done) begin
      cnt_q   <= '0;
      level_q <= key_sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
  assign press_o = done && key_sync_i;

  // R2: the debounced level moves only when the run counter has completed
  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(level_q));
  // R2: the run counter never passes its terminal value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_lock_watch.sv
module pwr_lock_watch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock_sync_i,
  output logic [N-1:0] loss_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lock_sync_i;
  end

  for (genvar p = 0; p < N; p++) begin : g_edge
    assign loss_o[p] = prev_q[p] & ~lock_sync_i[p];

    // R4: a loss pulse means the line was high the cycle before and is low now
    p_loss_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loss_o[p] |=> ($past(lock_sync_i[p]) == 1'b0) && ($past(prev_q[p]) == 1'b1));
  end
endmodule

// File: rtl/pwr_sticky_flag.sv
module pwr_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     flag_q <= RST_VAL;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!arst_n)
    set_i |=> flag_q);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (flag_q && !clr_i) |=> flag_q);
  p_w1c_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_i && !set_i) |=> !flag_q);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!flag_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/pwr_evt_status.sv
module pwr_evt_status
  import pwr_evt_pkg::*;
#(
  parameter int          DEB_CYCLES  = 16,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter logic [7:0]  STATUS_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              key_raw,
  input  logic [NUM_PLL-1:0] pll_lock,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(STATUS_ADDR);

  logic               rst_all_n;
  logic               key_sync;
  logic               key_level;
  logic               key_press;
  logic [NUM_PLL-1:0] lock_sync;
  logic [NUM_PLL-1:0] lock_loss;
  logic               hit;
  flag_vec_t          set_vec;
  flag_vec_t          clr_vec;
  flag_vec_t          flags;

  assign rst_all_n = por_n & rst_n;

  pwr_sync2 #(.W(1)) u_key_sync (
    .clk(clk), .rst_n(rst_all_n), .d_i(key_raw), .q_o(key_sync)
  );

  pwr_key_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_all_n), .key_sync_i(key_sync),
    .level_o(key_level), .press_o(key_press)
  );

  pwr_sync2 #(.W(NUM_PLL)) u_lock_sync (
    .clk(clk), .rst_n(rst_all_n), .d_i(pll_lock), .q_o(lock_sync)
  );

  pwr_lock_watch #(.N(NUM_PLL)) u_watch (
    .clk(clk), .rst_n(rst_all_n), .lock_sync_i(lock_sync), .loss_o(lock_loss)
  );

  assign hit     = (reg_addr == MY_ADDR);
  assign clr_vec = (reg_we && hit) ? reg_wdata[NUM_FLAGS-1:0] : '0;

  always_comb begin
    set_vec = '0;
    set_vec[FLAG_KEY] = key_press;
    set_vec[FLAG_PLL_LO +: NUM_PLL] = lock_loss;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    if (f == FLAG_POR) begin : g_por
      pwr_sticky_flag #(.RST_VAL(1'b1)) u_flag (
        .clk(clk), .arst_n(por_n), .set_i(1'b0),
        .clr_i(clr_vec[f]), .flag_o(flags[f])
      );
    end else begin : g_evt
      pwr_sticky_flag #(.RST_VAL(1'b0)) u_flag (
        .clk(clk), .arst_n(rst_all_n), .set_i(set_vec[f]),
        .clr_i(clr_vec[f]), .flag_o(flags[f])
      );
    end
  end

  assign reg_rdata = hit ? DATA_W'(flags) : '0;
  assign irq       = flags[FLAG_KEY];

  // R7: the power-on flag is held across a warm reset
  p_por_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !(reg_we && hit && reg_wdata[FLAG_POR])) |=> $stable(flags[FLAG_POR]));
  // R8: a write elsewhere clears no flag
  p_miss_noclr_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
    (reg_we && !hit && (flags != '0)) |=> (flags != '0));
  // R9: the interrupt tracks the key bit of the read word
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
    hit |-> (irq == reg_rdata[FLAG_KEY]));
endmodule

// File: tb/pwr_evt_status_tb.sv
module pwr_evt_status_tb_top;
  localparam int DEB = 4;
  localparam logic [7:0] ADDR = 8'h10;

  logic        clk = 1'b0;
  logic        por_n, rst_n, key_raw, reg_we, irq;
  logic [2:0]  pll_lock;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwr_evt_status #(.DEB_CYCLES(DEB), .ADDR_W(8), .DATA_W(32), .STATUS_ADDR(ADDR)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .key_raw(key_raw), .pll_lock(pll_lock),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = ADDR;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    por_n = 0; rst_n = 0; key_raw = 0; pll_lock = 3'b111;
    reg_we = 0; reg_addr = ADDR; reg_wdata = 0;
    idle(3);
    #1 check("R1 during por", reg_rdata, 32'h1);
    idle(2);
    por_n = 1; rst_n = 1;
    idle(6);
    rd(ADDR, v); check("R1 after por", v, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);
    wr(ADDR, 32'h1);

    // R2/R3/R9: sweep key pulse length across the debounce boundary
    for (int g = 1; g <= DEB + 3; g++) begin
      @(negedge clk); key_raw = 1;
      idle(g);
      key_raw = 0;
      idle(3 * DEB + 10);
      rd(ADDR, v);
      check($sformatf("R2 pulse %0d", g), v, (g >= DEB) ? 32'h10 : 32'h0);
      check("R9 irq", {31'b0, irq}, {31'b0, v[4]});
      if (g >= DEB) begin
        wr(ADDR, 32'h0F);
        rd(ADDR, v); check("R3 write zero keeps", v, 32'h10);
        wr(ADDR, 32'hFFFF_FFF0 | 32'h10);
        rd(ADDR, v); check("R3 w1c", v, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);
      end
    end

    // R4/R5/R10: all drop patterns
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); pll_lock = 3'b111 & ~3'(m);
      idle(6);
      rd(ADDR, v); check($sformatf("R4 drop %0d", m), v, 32'(m) << 1);
      pll_lock = 3'b111;
      idle(6);
      rd(ADDR, v); check("R10 relock sticky", v, 32'(m) << 1);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] e;
        e = (32'(m) << 1) & ~((32'h2 << k) - 32'h2 + ((32'h2 << k) - 32'h2));
        e = (32'(m) << 1) & ~(32'(((1 << (k + 1)) - 2)) | 32'h0);
        e = (32'(m) << 1) & ~(32'((1 << (k + 2)) - 2));
        wr(ADDR, 32'h2 << k);
        rd(ADDR, v); check($sformatf("R5 clear bit %0d", k + 1), v, e);
      end
    end

    // R6: clear coinciding with set of bit 3
    @(negedge clk); pll_lock[2] = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = ADDR; reg_wdata = 32'h8; reg_we = 1;
    @(negedge clk); reg_we = 0;
    rd(ADDR, v); check("R6 set wins", v, 32'h8);
    pll_lock[2] = 1; idle(6);
    wr(ADDR, 32'h8);
    rd(ADDR, v); check("R5 clear after R6", v, 32'h0);

    // R8: reserved bits, other address
    wr(ADDR, 32'hFFFF_FFFF);
    @(negedge clk); pll_lock[0] = 0; idle(6); pll_lock[0] = 1; idle(6);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(ADDR, v); check("R8 other write ignored", v, 32'h2);
    rd(8'h14, v); check("R8 other read zero", v, 32'h0);
    rd(ADDR, v); check("R8 reserved zero", v & 32'hFFFF_FFE0, 32'h0);
    wr(ADDR, 32'h2);

    // R7: warm reset vs power-on reset
    @(negedge clk); rst_n = 0; idle(3); rst_n = 1; idle(4);
    rd(ADDR, v); check("R7 warm keeps por", v, 32'h0);
    @(negedge clk); por_n = 0; idle(3); por_n = 1; idle(4);
    rd(ADDR, v); check("R7 por sets", v, 32'h1);
    @(negedge clk); pll_lock[1] = 0; idle(6); pll_lock[1] = 1; idle(6);
    @(negedge clk); rst_n = 0; idle(3); rst_n = 1; idle(4);
    rd(ADDR, v); check("R7 warm clears others keeps por", v, 32'h1);
    wr(ADDR, 32'h1);
    rd(ADDR, v); check("R7 por w1c", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule